// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block chooses which of five interrupt sources an 8-bit controller core should service next, and when. Once per machine cycle, on a late-phase strobe, it latches the raw request flags. At the strobe that ends the following machine cycle it polls that snapshot. The poll gates each flag with a master enable and a per-source enable, then splits the sources into a high group and a low group using a per-source level register. Inside each group the lowest source index wins.

A vector call is issued as a one-clock pulse that carries the service address and the level of the call. The call is issued only if three conditions hold: the routines already in service allow it, the CPU reports that the current cycle is the last cycle of an instruction, and that instruction is neither a return-from-interrupt nor a write to the enable or level register. The block keeps two in-service flags, one per level, which set the nesting rules. A request that is refused is not remembered. Only the next snapshot matters.

The enable and level registers are loaded through a plain byte-wide register write port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the enable register and the level register are zero, both in-service flags are clear, and `vec_req` is low. As a result, no source is granted until the enable register is written.
- R2: Flags present at the clock edge where `cyc_stb` is high are captured. They are polled at the next edge where `cyc_stb` is high. A grant produces `vec_req` for exactly one clock, starting on that second strobe edge. Flags that change between strobes have no effect.
- R3: The enable register is at address A8h. Bit 7 is the master enable, and bits 0 to 4 enable sources 0 to 4. A source whose own enable bit is clear, or any source while bit 7 is clear, is never granted.
- R4: The level register is at address B8h. Bit n set places source n in the high group. When enabled requests exist in both groups in the same poll, the high group wins, and `vec_hi` is 1 for a high-group call.
- R5: Within one group the lowest index wins. The indices are: 0 = external 0, 1 = timer 0 overflow, 2 = external 1, 3 = timer 1 overflow, 4 = serial port.
- R6: `vec_addr` equals 0003h + 8·n, where n is the index of the granted source.
- R7: No call is made at a poll where `last_cyc` is low.
- R8: No call is made at a poll where `blk_instr` is high. A request whose flag is still set in the snapshot polled afterwards is then granted.
- R9: While the low in-service flag is set, low-group requests are refused and high-group requests are granted. While the high in-service flag is set, every request is refused.
- R10: A refused request is not retained. If its flag is clear in the next polled snapshot, no call is made for it.
- R11: A grant sets the in-service flag of its level (`isr_active[1]` = high, `isr_active[0]` = low). A `reti_exec` pulse clears the high flag if it is set, and otherwise clears the low flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb | input | 1 | Late-phase strobe, one clock per machine cycle |
| irq_flags | input | 5 | Raw request flags, index 0 to 4 |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| last_cyc | input | 1 | Current machine cycle is the last one of the instruction |
| blk_instr | input | 1 | Current instruction is a return-from-interrupt or a write to the enable or level register |
| reti_exec | input | 1 | One-clock pulse when a return-from-interrupt executes |
| vec_req | output | 1 | Vector call request pulse |
| vec_addr | output | 16 | Service address of the call |
| vec_hi | output | 1 | Call belongs to the high group |
| isr_active | output | 2 | In-service flags: bit 1 high, bit 0 low |

## Verification
The bench builds the block with its default configuration: five sources, 16-bit addresses, base 0003h and stride 8. This is small enough to sweep every combination of the level register and the request pattern, and every per-source enable mask. For each combination the winner and its address are computed arithmetically. Directed sequences built on this configuration cover the strobe-to-strobe latency, preemption and refusal under both in-service flags, the return-order of the flags, and requests that vanish or persist across a blocked poll.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int NUM_SRC  = 5;
    localparam int IDX_W    = 3;
    localparam int ADDR_W   = 16;
    localparam int VEC_BASE = 3;
    localparam int VEC_STEP = 8;
    localparam int NUM_LVL  = 2;
    localparam int LVL_HI   = 1;
    localparam int LVL_LO   = 0;

    localparam logic [7:0] SFR_EN_ADDR  = 8'hA8;
    localparam logic [7:0] SFR_LVL_ADDR = 8'hB8;
    localparam int         MASTER_BIT   = 7;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } poll_t;

    function automatic logic [ADDR_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        logic [ADDR_W-1:0] a;
        a = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(idx);
        return a;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import prio_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [7:0]   addr,
    input  logic [7:0]   wdata,
    output logic         master_en,
    output logic [N-1:0] src_en,
    output logic [N-1:0] lvl_hi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            master_en <= 1'b0;
            src_en    <= '0;
            lvl_hi    <= '0;
        end else if (we) begin
            if (addr == SFR_EN_ADDR) begin
                master_en <= wdata[MASTER_BIT];
                src_en    <= wdata[N-1:0];
            end
            if (addr == SFR_LVL_ADDR) begin
                lvl_hi <= wdata[N-1:0];
            end
        end
    end

    p_cfg_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (lvl_hi == '0 && src_en == '0 && !master_en));

endmodule

// File: rtl/irq_sampler.sv
module irq_sampler
    import prio_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  logic [N-1:0] flags,
    output logic [N-1:0] snap
);

    always_ff @(posedge clk) begin
        if (rst)      snap <= '0;
        else if (stb) snap <= flags;
    end

    p_snap_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(stb) && !$past(rst) |-> $stable(snap));

endmodule

// File: rtl/irq_level_poll.sv
module irq_level_poll
    import prio_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] pend,
    output poll_t        res
);

    always_comb begin
        res = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                res.hit = 1'b1;
                res.idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track
    import prio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       grant,
    input  logic       grant_hi,
    input  logic       reti,
    output logic       act_hi,
    output logic       act_lo
);

    logic nxt_hi, nxt_lo;

    always_comb begin
        nxt_hi = act_hi;
        nxt_lo = act_lo;
        if (reti) begin
            if (act_hi) nxt_hi = 1'b0;
            else        nxt_lo = 1'b0;
        end
        if (grant) begin
            if (grant_hi) nxt_hi = 1'b1;
            else          nxt_lo = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_hi <= 1'b0;
            act_lo <= 1'b0;
        end else begin
            act_hi <= nxt_hi;
            act_lo <= nxt_lo;
        end
    end

    p_reti_order_r11: assert property (@(posedge clk) disable iff (rst)
        reti && !grant && act_hi |=> !act_hi && (act_lo == $past(act_lo)));

    p_grant_sets_r11: assert property (@(posedge clk) disable iff (rst)
        grant && grant_hi |=> act_hi);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int N = NUM_SRC,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc_stb,
    input  logic [N-1:0]  irq_flags,
    input  logic          sfr_we,
    input  logic [7:0]    sfr_addr,
    input  logic [7:0]    sfr_wdata,
    input  logic          last_cyc,
    input  logic          blk_instr,
    input  logic          reti_exec,
    output logic          vec_req,
    output logic [AW-1:0] vec_addr,
    output logic          vec_hi,
    output logic [1:0]    isr_active
);

    logic         master_en;
    logic [N-1:0] src_en;
    logic [N-1:0] lvl_hi;
    logic [N-1:0] snap;
    logic [N-1:0] pend;
    logic [N-1:0] pend_lv [NUM_LVL];
    poll_t        res_lv  [NUM_LVL];
    logic         act_hi, act_lo;
    logic         take_hi, take_lo, gate, grant;
    logic [IDX_W-1:0] win_idx;

    irq_cfg_regs #(.N(N)) u_regs (
        .clk(clk), .rst(rst), .we(sfr_we), .addr(sfr_addr), .wdata(sfr_wdata),
        .master_en(master_en), .src_en(src_en), .lvl_hi(lvl_hi)
    );

    irq_sampler #(.N(N)) u_samp (
        .clk(clk), .rst(rst), .stb(cyc_stb), .flags(irq_flags), .snap(snap)
    );

    assign pend              = snap & src_en & {N{master_en}};
    assign pend_lv[LVL_HI]   = pend & lvl_hi;
    assign pend_lv[LVL_LO]   = pend & ~lvl_hi;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        irq_level_poll #(.N(N)) u_poll (
            .pend(pend_lv[g]), .res(res_lv[g])
        );
    end

    assign take_hi = res_lv[LVL_HI].hit && !act_hi;
    assign take_lo = !res_lv[LVL_HI].hit && res_lv[LVL_LO].hit && !act_hi && !act_lo;
    assign gate    = cyc_stb && last_cyc && !blk_instr;
    assign grant   = gate && (take_hi || take_lo);
    assign win_idx = take_hi ? res_lv[LVL_HI].idx : res_lv[LVL_LO].idx;

    irq_nest_track u_nest (
        .clk(clk), .rst(rst), .grant(grant), .grant_hi(take_hi),
        .reti(reti_exec), .act_hi(act_hi), .act_lo(act_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_req  <= 1'b0;
            vec_addr <= '0;
            vec_hi   <= 1'b0;
        end else begin
            vec_req <= grant;
            if (grant) begin
                vec_addr <= AW'(vec_of(win_idx));
                vec_hi   <= take_hi;
            end
        end
    end

    assign isr_active = {act_hi, act_lo};

    p_call_on_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> $past(cyc_stb));

    p_call_needs_end_r7: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> $past(last_cyc));

    p_call_not_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> !$past(blk_instr));

    p_hi_unpreempted_r9: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> !$past(act_hi));

    p_lo_needs_idle_r9: assert property (@(posedge clk) disable iff (rst)
        vec_req && !vec_hi |-> !$past(act_lo));

    p_master_gate_r3: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> $past(master_en));

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

    localparam int N = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_stb = 1'b0;
    logic [N-1:0] irq_flags = '0;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_addr = '0;
    logic [7:0]  sfr_wdata = '0;
    logic        last_cyc = 1'b0;
    logic        blk_instr = 1'b0;
    logic        reti_exec = 1'b0;
    logic        vec_req;
    logic [15:0] vec_addr;
    logic        vec_hi;
    logic [1:0]  isr_active;

    int checks = 0;
    int errors = 0;
    logic        got_req;
    logic [15:0] got_addr;
    logic        got_hi;

    always #10 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .irq_flags(irq_flags),
        .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .last_cyc(last_cyc), .blk_instr(blk_instr), .reti_exec(reti_exec),
        .vec_req(vec_req), .vec_addr(vec_addr), .vec_hi(vec_hi),
        .isr_active(isr_active)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic mcycle(input logic last, input logic blk);
        @(negedge clk);
        last_cyc = last; blk_instr = blk;
        repeat (2) @(negedge clk);
        cyc_stb = 1'b1;
        @(negedge clk);
        cyc_stb = 1'b0; last_cyc = 1'b0; blk_instr = 1'b0;
        got_req = vec_req; got_addr = vec_addr; got_hi = vec_hi;
    endtask

    task automatic reti();
        @(negedge clk);
        reti_exec = 1'b1;
        @(negedge clk);
        reti_exec = 1'b0;
    endtask

    function automatic int lowest(input logic [N-1:0] m);
        for (int i = 0; i < N; i++) if (m[i]) return i;
        return -1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 vec_req", vec_req, 0);
        chk("R1 isr_active", isr_active, 0);
        irq_flags = '1;
        mcycle(1, 0);
        mcycle(1, 0);
        chk("R1 no grant with reset enables", got_req, 0);
        irq_flags = '0;
        mcycle(0, 0);

        // R2 latency and pulse width
        wr(8'hA8, 8'h9F);
        wr(8'hB8, 8'h00);
        irq_flags = 5'b00100;
        mcycle(1, 0);
        chk("R2 not before next poll", got_req, 0);
        irq_flags = '0;
        mcycle(1, 0);
        chk("R2 grant after one cycle", got_req, 1);
        chk("R6 addr src2", got_addr, 16'h13);
        @(negedge clk);
        chk("R2 one-clock pulse", vec_req, 0);
        mcycle(0, 0);
        reti();
        chk("R11 low cleared", isr_active, 0);

        // Sweep: level register x request pattern (R4 R5 R6 R7 R11)
        for (int p = 0; p < 32; p++) begin
            wr(8'hB8, 8'(p));
            for (int r = 0; r < 32; r++) begin
                logic [N-1:0] hi_m, lo_m;
                int w;
                logic exp_hi;
                hi_m = 5'(r) & 5'(p);
                lo_m = 5'(r) & ~5'(p);
                exp_hi = (hi_m != 0);
                w = exp_hi ? lowest(hi_m) : lowest(lo_m);
                irq_flags = 5'(r);
                mcycle(0, 0);
                chk("R7 not last cycle", got_req, 0);
                mcycle(1, 0);
                irq_flags = '0;
                chk("R4 R5 grant", got_req, (r != 0) ? 1 : 0);
                if (r != 0) begin
                    chk("R6 addr", got_addr, 32'(3 + 8 * w));
                    chk("R4 level", got_hi, exp_hi);
                    chk("R11 set", isr_active, exp_hi ? 2 : 1);
                end
                mcycle(0, 0);
                reti();
                chk("R11 reti clears", isr_active, 0);
            end
        end

        // R3: per-source enable sweep, all requests raised, all low group
        wr(8'hB8, 8'h00);
        for (int m = 0; m < 32; m++) begin
            wr(8'hA8, 8'h80 | 8'(m));
            irq_flags = '1;
            mcycle(0, 0);
            mcycle(1, 0);
            irq_flags = '0;
            chk("R3 enable mask", got_req, (m != 0) ? 1 : 0);
            if (m != 0) chk("R3 enabled winner", got_addr, 32'(3 + 8 * lowest(5'(m))));
            mcycle(0, 0);
            reti();
        end
        wr(8'hA8, 8'h1F);
        irq_flags = '1;
        mcycle(0, 0);
        mcycle(1, 0);
        irq_flags = '0;
        chk("R3 master off", got_req, 0);
        mcycle(0, 0);

        // R9: nesting
        wr(8'hA8, 8'h9F);
        wr(8'hB8, 8'h04);
        irq_flags = 5'b00001;
        mcycle(0, 0);
        mcycle(1, 0);
        irq_flags = 5'b00010;
        chk("R9 low granted when idle", got_req, 1);
        mcycle(1, 0);
        mcycle(1, 0);
        chk("R9 low blocked by low", got_req, 0);
        chk("R9 low flag only", isr_active, 1);
        irq_flags = 5'b00110;
        mcycle(0, 0);
        mcycle(1, 0);
        chk("R9 high preempts low", got_req, 1);
        chk("R9 high addr", got_addr, 16'h13);
        chk("R11 both flags", isr_active, 3);
        mcycle(1, 0);
        mcycle(1, 0);
        chk("R9 nothing preempts high", got_req, 0);
        irq_flags = '0;
        mcycle(0, 0);
        mcycle(0, 0);
        reti();
        chk("R11 high cleared first", isr_active, 1);
        reti();
        chk("R11 low cleared next", isr_active, 0);

        // R8 and R10: blocking instruction
        wr(8'hB8, 8'h00);
        irq_flags = 5'b01000;
        mcycle(0, 0);
        mcycle(1, 1);
        chk("R8 blocked poll", got_req, 0);
        mcycle(1, 0);
        irq_flags = '0;
        chk("R8 served after block", got_req, 1);
        chk("R8 addr", got_addr, 16'h1B);
        mcycle(0, 0);
        reti();
        irq_flags = 5'b01000;
        mcycle(0, 0);
        mcycle(1, 1);
        chk("R8 blocked again", got_req, 0);
        irq_flags = '0;
        mcycle(0, 0);
        mcycle(1, 0);
        chk("R10 dropped request forgotten", got_req, 0);
        chk("R10 no in-service", isr_active, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule